// File: doc/BRIEF.md
# Digital Filtered PLL Lock Detector

This block decides whether a phase-locked loop is in lock by watching the two signals that feed its phase detector. One is the reference clock. The other is the feedback-divider output. Both raw inputs are brought into a fast sampling-clock domain. There, every 64th rising edge of each input is taken as one leading edge of a divided-by-64 signal. The time from one divided leading edge to the matching edge of the other input is counted in sampling-clock periods. That count is the skew, and it is compared against a programmable window.

A filter sits behind the comparison. It raises the lock flag only after a run of four in-window comparisons in a row. A single comparison outside the window drops the flag and restarts the run. An enable input forces the flag low at any time and also discards the run, so lock must be earned again after re-enabling. The length of the current run, capped at four, is brought out for debug.

Top module: `pll_lock_filter`

## Requirements
- R1: Exactly one phase comparison is made per 64 rising edges of each input. After reset, 63 edge pairs leave `run_cnt` at 0, and the 64th pair produces the first comparison.
- R2: The skew is the number of `clk` cycles between the two divided leading edges, as seen after identical synchronisers. The window width `win` is given in the same unit.
- R3: A comparison is in-window when the skew is strictly less than `win`, whichever input leads. When the skew equals `win`, the result is unspecified.
- R4: `lock` goes high only after 4 consecutive in-window comparisons. After 1, 2 and 3 of them, `lock` stays 0 and `run_cnt` reads 1, 2 and 3.
- R5: One comparison whose skew exceeds `win` clears `lock` and sets `run_cnt` to 0.
- R6: While `en` is 0, `lock` is 0 in the same cycle, and comparisons have no effect on it.
- R7: Clearing `en` sets `run_cnt` to 0 within one cycle. After `en` returns to 1, four new in-window comparisons are needed before `lock` rises.
- R8: If the second divided edge has not arrived 511 `clk` cycles after the first, the comparison is scored out-of-window.
- R9: A synchronous active-low reset clears both divide-by-64 counters, the run count and `lock`.
- R10: `run_cnt` saturates at 4 while in-window comparisons continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock; all state is clocked by it |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | 1 lets the detector report lock; 0 forces `lock` low and clears the run |
| ref_in | input | 1 | Reference clock into the phase detector (asynchronous) |
| fb_in | input | 1 | Feedback-divider output into the phase detector (asynchronous) |
| win | input | WIN_W (8) | Window width in `clk` cycles |
| lock | output | 1 | Filtered lock status |
| run_cnt | output | $clog2(LOCK_RUN+1) (3) | Consecutive in-window comparisons, saturating at LOCK_RUN (4) |

## Verification
Suppose a divider count is off: the two inputs are then paired on different edges. The result is a skew of a whole input period, so `run_cnt` falls to 0 at the next comparison. Separately, a divider that wraps early or late shows up as a run count that moves on the wrong input pulse, up to 64 input periods away.

A run counter that misses a clear shows `lock` rising after fewer than four fresh comparisons, within one divided period. A measurement stuck in a wait state shows only after the 511-cycle timeout, as a lock drop with no matching skew.

// File: rtl/lock_pkg.sv
// Package: shared types for the PLL lock detector.
// Assumes: nothing beyond IEEE 1800-2017.
package lock_pkg;

    // State of the skew measurement: idle, or waiting for the partner edge.
    typedef enum logic [1:0] {
        SK_IDLE     = 2'd0,
        SK_WAIT_FB  = 2'd1,
        SK_WAIT_REF = 2'd2
    } skew_state_e;

    // Channel indices for the two phase-detector inputs.
    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/lock_edge_sync.sv
// Module: lock_edge_sync
// Brings one asynchronous input into the clk domain through a chain of
// STAGES flops, then emits a one-cycle pulse on each rising edge.
// Assumes: the input stays high and low for at least two clk periods each.
module lock_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the input through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], sig_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lock_div.sv
// Module: lock_div
// Counts rising-edge pulses and passes on every RATIO-th one. The pulse
// that is passed on marks the leading edge of the divided signal.
// Assumes: edge_i is a single-cycle pulse.
module lock_div #(
    parameter int RATIO = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic pulse_o
);

    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q;

    // Advance the edge count and wrap after the last edge of a group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (edge_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign pulse_o = edge_i && (cnt_q == LAST);

    AST_DIV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> (cnt_q == '0)); // R1

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/lock_skew_meas.sv
// Module: lock_skew_meas
// Measures, in clk cycles, the distance between a divided reference edge
// and the matching divided feedback edge. Either may come first. It issues
// a one-cycle verdict that says whether the skew was strictly below the
// window. When the partner edge does not come before the counter saturates,
// the verdict is out-of-window.
// Assumes: divided pulses of one channel are far more than 2 cycles apart.
module lock_skew_meas
    import lock_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_p,
    input  logic             fb_p,
    input  logic [WIN_W-1:0] win,
    output logic             valid_o,
    output logic             in_win_o
);

    localparam int CNT_W = WIN_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    skew_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] win_ext;
    logic             partner;

    assign win_ext = {1'b0, win};
    assign partner = (state_q == SK_WAIT_FB) ? fb_p : ref_p;

    // Track the first edge, count the skew and issue one verdict per pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SK_IDLE;
            cnt_q    <= '0;
            valid_o  <= 1'b0;
            in_win_o <= 1'b0;
        end else begin
            valid_o  <= 1'b0;
            in_win_o <= 1'b0;
            case (state_q)
                SK_IDLE: begin
                    if (ref_p && fb_p) begin
                        valid_o  <= 1'b1;
                        in_win_o <= (win_ext != '0);
                    end else if (ref_p) begin
                        state_q <= SK_WAIT_FB;
                        cnt_q   <= CNT_W'(1);
                    end else if (fb_p) begin
                        state_q <= SK_WAIT_REF;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                SK_WAIT_FB, SK_WAIT_REF: begin
                    if (partner) begin
                        valid_o  <= 1'b1;
                        in_win_o <= (cnt_q < win_ext);
                        state_q  <= SK_IDLE;
                    end else if (cnt_q == CNT_MAX) begin
                        valid_o  <= 1'b1;
                        in_win_o <= 1'b0;
                        state_q  <= SK_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SK_IDLE;
            endcase
        end
    end

    AST_VERDICT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R2

    AST_INWIN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_win_o |-> valid_o); // R3

    AST_TIMEOUT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SK_IDLE && cnt_q == CNT_MAX && !partner)
            |=> (valid_o && !in_win_o && state_q == SK_IDLE)); // R8

endmodule

// File: rtl/lock_run_filter.sv
// Module: lock_run_filter
// Counts consecutive in-window verdicts up to LOCK_RUN and raises lock when
// the run is complete. One out-of-window verdict clears both. A low enable
// forces lock low at once and discards the run.
// Assumes: valid_i is a single-cycle strobe.
module lock_run_filter #(
    parameter int LOCK_RUN = 4,
    parameter int RUN_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             valid_i,
    input  logic             in_win_i,
    output logic             lock_o,
    output logic [RUN_W-1:0] run_o
);

    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUN);
    localparam logic [RUN_W-1:0] RUN_PRE  = RUN_W'(LOCK_RUN - 1);

    logic [RUN_W-1:0] run_q;
    logic             lock_q;

    // Update the consecutive run and the lock flag on each verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (!en) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (valid_i) begin
            if (in_win_i) begin
                if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
                if (run_q >= RUN_PRE) lock_q <= 1'b1;
            end else begin
                run_q  <= '0;
                lock_q <= 1'b0;
            end
        end
    end

    assign lock_o = lock_q & en;
    assign run_o  = run_q;

    AST_LOCK_RUN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> (run_q == RUN_FULL)); // R4

    AST_LOCK_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(valid_i && in_win_i && en)); // R4

    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && valid_i && !in_win_i) |=> (run_q == '0 && !lock_q)); // R5

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (run_q == '0 && !lock_q)); // R7

    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_FULL); // R10

endmodule

// File: rtl/pll_lock_filter.sv
// Module: pll_lock_filter (top)
// Digital filtered lock detector. Each phase-detector input is synchronised
// and reduced to its rising edges, then divided by DIV_RATIO. The skew
// between the divided leading edges is compared with the window, and a
// run of LOCK_RUN in-window results raises lock.
// Assumes: ref_in and fb_in pulses are much slower than clk.
module pll_lock_filter
    import lock_pkg::*;
#(
    parameter int DIV_RATIO   = 64,
    parameter int LOCK_RUN    = 4,
    parameter int WIN_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int RUN_W      = $clog2(LOCK_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [WIN_W-1:0] win,
    output logic             lock,
    output logic [RUN_W-1:0] run_cnt
);

    logic [N_CH-1:0] raw;
    logic [N_CH-1:0] rise;
    logic [N_CH-1:0] div_p;
    logic            cmp_valid;
    logic            cmp_in_win;

    assign raw[CH_REF] = ref_in;
    assign raw[CH_FB]  = fb_in;

    // One synchroniser and one divider per phase-detector input.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        lock_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (raw[ch]),
            .rise_o (rise[ch])
        );
        lock_div #(.RATIO(DIV_RATIO)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_i  (rise[ch]),
            .pulse_o (div_p[ch])
        );
    end

    lock_skew_meas #(.WIN_W(WIN_W)) u_skew (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_p    (div_p[CH_REF]),
        .fb_p     (div_p[CH_FB]),
        .win      (win),
        .valid_o  (cmp_valid),
        .in_win_o (cmp_in_win)
    );

    lock_run_filter #(.LOCK_RUN(LOCK_RUN), .RUN_W(RUN_W)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .valid_i  (cmp_valid),
        .in_win_i (cmp_in_win),
        .lock_o   (lock),
        .run_o    (run_cnt)
    );

    AST_EN_LOW_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !lock); // R6

endmodule

// File: tb/pll_lock_filter_tb.sv
module pll_lock_filter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [7:0] win = 8'd6;
    logic       lock;
    logic [2:0] run_cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pll_lock_filter u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ref_in  (ref_in),
        .fb_in   (fb_in),
        .win     (win),
        .lock    (lock),
        .run_cnt (run_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input int exp_run, input int exp_lock);
        check(run_cnt == 3'(exp_run), req, int'(run_cnt), exp_run);
        check(lock == 1'(exp_lock), req, int'(lock), exp_lock);
    endtask

    // n input pulses, 16 clocks each; d > 0: fb lags ref by d, d < 0: fb leads.
    task automatic pulses(input int n, input int d, input bit fb_on = 1'b1);
        int a = (d < 0) ? -d : 0;
        int b = (d > 0) ? d : 0;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                ref_in = (k >= a) && (k < a + 4);
                fb_in  = fb_on && (k >= b) && (k < b + 4);
            end
        end
        @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        expect_state("R9 reset", 0, 0);
    endtask

    task automatic t_divide();
        pulses(63, 3);
        expect_state("R1 no comparison before 64th edge", 0, 0);
        pulses(1, 3);
        expect_state("R1 R2 first comparison on 64th edge", 1, 0);
    endtask

    task automatic t_acquire();
        pulses(64, 3);
        expect_state("R4 run 2", 2, 0);
        pulses(64, 3);
        expect_state("R4 run 3", 3, 0);
        pulses(64, 3);
        expect_state("R4 locked on 4th", 4, 1);
    endtask

    task automatic t_saturate();
        pulses(64, -2);
        expect_state("R10 R3 fb leads, run capped", 4, 1);
    endtask

    task automatic t_drop();
        pulses(64, 9);
        expect_state("R5 single miss drops lock", 0, 0);
    endtask

    task automatic t_enable();
        for (int i = 0; i < 4; i++) pulses(64, 3);
        expect_state("R4 relocked", 4, 1);
        @(negedge clk);
        en = 1'b0;
        #1;
        check(lock == 1'b0, "R6 lock low same cycle", int'(lock), 0);
        repeat (2) @(negedge clk);
        check(run_cnt == 3'd0, "R7 run cleared by disable", int'(run_cnt), 0);
        pulses(64, 3);
        expect_state("R6 comparisons ignored while disabled", 0, 0);
        en = 1'b1;
        for (int i = 0; i < 3; i++) pulses(64, 3);
        expect_state("R7 three after re-enable not enough", 3, 0);
        pulses(64, 3);
        expect_state("R7 lock re-earned", 4, 1);
    endtask

    task automatic t_equal();
        pulses(64, 6);
        pulses(64, 9);
        expect_state("R5 miss after equal-skew case", 0, 0);
    endtask

    task automatic t_window();
        win = 8'd12;
        for (int i = 0; i < 4; i++) pulses(64, 9);
        expect_state("R2 R3 skew 9 inside window 12", 4, 1);
    endtask

    task automatic t_timeout();
        pulses(64, 0, 1'b0);
        repeat (200) @(negedge clk);
        expect_state("R8 still waiting before timeout", 4, 1);
        repeat (400) @(negedge clk);
        expect_state("R8 missing partner scored out", 0, 0);
    endtask

    task automatic t_reset_realign();
        win = 8'd6;
        do_reset();
        expect_state("R9 reset after timeout", 0, 0);
        pulses(63, 2);
        expect_state("R9 dividers cleared", 0, 0);
        pulses(1, 2);
        expect_state("R9 first comparison after reset", 1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_divide();
        t_acquire();
        t_saturate();
        t_drop();
        t_enable();
        t_equal();
        t_window();
        t_timeout();
        t_reset_realign();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule